// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the strobe sequence for one programmed-I/O transfer on an IDE channel that carries two drives. Each transfer has three phases, all counted in host clocks. The address-valid phase comes first. The data pulse follows, with the read or write strobe high. A recovery gap closes the transfer. A single-clock done pulse then marks the end of the transfer.

Two timing banks each hold a read byte and a write byte. These bytes set the pulse and recovery lengths. A mapping register decides which bank each drive uses. The address-setup length does not live in the banks: it is one shared field of a common settings register, so both drives always use the same setup time. That register also holds a read-prefetch enable and a ready-wait count, which are passed straight to outputs.

Host logic writes the configuration bytes through a simple write port. It then raises a request together with a direction and a drive number. The block takes the request only when it is idle and reports `busy` until the transfer is over.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset every timing byte is 0x00, so each drive and direction gives 1 setup clock, 1 pulse clock and 2 recovery clocks. The mapping and settings registers are 0x00. The outputs are idle, `prefetch_en` is 0 and `drdy_clks` is 2.
- R2: In a timing byte, bits 7:4 hold the pulse length minus 1 (1 to 16 clocks) and bits 3:0 hold the recovery length minus 2 (2 to 17 clocks).
- R3: Bits 5:4 of the settings register (address 5) hold the setup length minus 1 (1 to 4 clocks). Both drives use this one value.
- R4: In the mapping register (address 4), bit 1 picks the bank for drive 0 and bit 2 picks the bank for drive 1 (0 means bank A, 1 means bank B). The value 0x85 maps bank A to drive 0 and bank B to drive 1.
- R5: The timing addresses are 0 for bank A read, 1 for bank A write, 2 for bank B read and 3 for bank B write. A read transfer uses the read byte of the mapped bank. A write transfer uses that bank's write byte.
- R6: `addr_valid` is high through the setup and pulse phases. The strobe that matches the direction (`rd_strobe` or `wr_strobe`) is high only during the pulse phase. The other strobe stays low.
- R7: `cyc_done` is high for exactly one clock, in the clock right after the last recovery clock.
- R8: A request is taken only when `busy` is low. `busy` is high from the first setup clock through the done clock. A request raised while busy and dropped before the block is idle again starts no transfer.
- R9: The lengths are captured when the request is taken. A register write during a transfer changes only later transfers.
- R10: Bit 6 of the settings register drives `prefetch_en`. `drdy_clks` equals settings bits 3:1 plus 2.
- R11: A write to address 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_req | input | 1 | Transfer request |
| cyc_write | input | 1 | Direction of the request: 1 for write, 0 for read |
| cyc_drive | input | 1 | Target drive (0 or 1) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| addr_valid | output | 1 | Address valid (setup and pulse phases) |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| cyc_done | output | 1 | End-of-transfer pulse |
| prefetch_en | output | 1 | Read-prefetch enable |
| drdy_clks | output | 4 | Ready-wait count in clocks |

## Verification
The bench drives the extreme field values: a 16-clock pulse with the shortest recovery, a 17-clock recovery, and the 4-clock setup. A design that dropped a bit of a field, or was off by one in a length offset, would stretch or shorten a phase. The bench also swaps the bank mapping in both directions. A design that routed the bank by drive number alone, or took the wrong byte for the direction, would give the lengths of the other byte. Finally, the bench pokes both the request and a configuration write into a running transfer. A design that re-read the registers mid-transfer, or accepted a request while busy, would show a changed phase length or a second transfer where the bench expects idle.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;
  localparam int TMG_W   = 8;
  localparam int LEN_W   = 5;
  localparam int ADDR_W  = 3;
  localparam int N_BANKS = 2;
  localparam int N_TMG   = N_BANKS * 2;

  localparam logic [ADDR_W-1:0] ADR_MAP  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MISC = 3'd5;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_RECOV = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // pulse clocks from the upper nibble of a timing byte
  function automatic logic [LEN_W-1:0] pulse_len(input logic [TMG_W-1:0] b);
    return {1'b0, b[7:4]} + LEN_W'(1);
  endfunction

  // recovery clocks from the lower nibble of a timing byte
  function automatic logic [LEN_W-1:0] recov_len(input logic [TMG_W-1:0] b);
    return {1'b0, b[3:0]} + LEN_W'(2);
  endfunction

  // shared setup clocks from the settings register
  function automatic logic [LEN_W-1:0] setup_len(input logic [TMG_W-1:0] m);
    return {3'b000, m[5:4]} + LEN_W'(1);
  endfunction

  function automatic logic [3:0] drdy_len(input logic [TMG_W-1:0] m);
    return {1'b0, m[3:1]} + 4'd2;
  endfunction
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_tmg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [TMG_W-1:0]             wdata,
  output logic [N_TMG-1:0][TMG_W-1:0]  tmg_q,
  output logic [TMG_W-1:0]             map_q,
  output logic [TMG_W-1:0]             misc_q
);
  for (genvar e = 0; e < N_TMG; e++) begin : g_tmg
    logic [TMG_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (we && addr == ADDR_W'(e))
        ent_q <= wdata;
    end
    assign tmg_q[e] = ent_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q  <= '0;
      misc_q <= '0;
    end else if (we) begin
      if (addr == ADR_MAP)  map_q  <= wdata;
      if (addr == ADR_MISC) misc_q <= wdata;
    end
  end
endmodule

// File: rtl/pio_bank_sel.sv
module pio_bank_sel
  import pio_tmg_pkg::*;
(
  input  logic [N_TMG-1:0][TMG_W-1:0] tmg_q,
  input  logic [1:0]                  drv_bank,
  input  logic                        drive,
  input  logic                        write,
  output logic [TMG_W-1:0]            sel_byte
);
  logic bank;
  logic [1:0] idx;

  always_comb begin
    bank     = drive ? drv_bank[1] : drv_bank[0];
    idx      = {bank, write};
    sel_byte = tmg_q[idx];
  end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_tmg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             write,
  input  logic [LEN_W-1:0] setup_clks,
  input  logic [LEN_W-1:0] pulse_clks,
  input  logic [LEN_W-1:0] recov_clks,
  output phase_e           phase,
  output logic             accept,
  output logic             busy,
  output logic             addr_valid,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             done
);
  phase_e           ph_q;
  logic [LEN_W-1:0] cnt_q, pulse_q, recov_q;
  logic             wr_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = req && (ph_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      pulse_q <= LEN_W'(1);
      recov_q <= LEN_W'(2);
      wr_q    <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (req) begin
          ph_q    <= PH_SETUP;
          cnt_q   <= setup_clks - LEN_W'(1);
          pulse_q <= pulse_clks;
          recov_q <= recov_clks;
          wr_q    <= write;
        end
        PH_SETUP: if (cnt_zero) begin
          ph_q  <= PH_PULSE;
          cnt_q <= pulse_q - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        PH_PULSE: if (cnt_zero) begin
          ph_q  <= PH_RECOV;
          cnt_q <= recov_q - LEN_W'(1);
        end else cnt_q <= cnt_q - LEN_W'(1);
        PH_RECOV: if (cnt_zero) ph_q <= PH_DONE;
                  else cnt_q <= cnt_q - LEN_W'(1);
        PH_DONE:  ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = ph_q;
  assign busy       = (ph_q != PH_IDLE);
  assign addr_valid = (ph_q == PH_SETUP) || (ph_q == PH_PULSE);
  assign rd_strobe  = (ph_q == PH_PULSE) && !wr_q;
  assign wr_strobe  = (ph_q == PH_PULSE) && wr_q;
  assign done       = (ph_q == PH_DONE);
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_tmg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_req,
  input  logic        cyc_write,
  input  logic        cyc_drive,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic        busy,
  output logic        addr_valid,
  output logic        rd_strobe,
  output logic        wr_strobe,
  output logic        cyc_done,
  output logic        prefetch_en,
  output logic [3:0]  drdy_clks
);
  logic [N_TMG-1:0][TMG_W-1:0] tmg_q;
  logic [TMG_W-1:0]            map_q, misc_q, sel_byte;
  phase_e                      phase;
  logic                        accept;
  logic                        unused_cfg_bits;

  pio_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .tmg_q  (tmg_q),
    .map_q  (map_q),
    .misc_q (misc_q)
  );

  pio_bank_sel u_sel (
    .tmg_q    (tmg_q),
    .drv_bank (map_q[2:1]),
    .drive    (cyc_drive),
    .write    (cyc_write),
    .sel_byte (sel_byte)
  );

  pio_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (cyc_req),
    .write      (cyc_write),
    .setup_clks (setup_len(misc_q)),
    .pulse_clks (pulse_len(sel_byte)),
    .recov_clks (recov_len(sel_byte)),
    .phase      (phase),
    .accept     (accept),
    .busy       (busy),
    .addr_valid (addr_valid),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .done       (cyc_done)
  );

  assign prefetch_en     = misc_q[6];
  assign drdy_clks       = drdy_len(misc_q);
  assign unused_cfg_bits = ^{map_q[7:3], map_q[0], misc_q[7], misc_q[0]};
endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk
  import pio_tmg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cyc_req,
  input logic   accept,
  input phase_e phase,
  input logic   busy,
  input logic   addr_valid,
  input logic   rd_strobe,
  input logic   wr_strobe,
  input logic   cyc_done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe)); // R6
  AST_STROBE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe || wr_strobe) |-> addr_valid); // R6
  AST_PULSE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PULSE) |-> (rd_strobe || wr_strobe)); // R6
  AST_RECOV_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV) |-> !addr_valid); // R6
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R7
  AST_DONE_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> ($past(phase) == PH_RECOV)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(addr_valid || rd_strobe || wr_strobe || cyc_done)); // R8
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !busy) |=> (addr_valid && busy)); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> busy); // R8
endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_req    (cyc_req),
  .accept     (accept),
  .phase      (phase),
  .busy       (busy),
  .addr_valid (addr_valid),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .cyc_done   (cyc_done)
);

// File: tb/pio_cycle_timer_tb.sv
`timescale 1ns/1ps
module pio_cycle_timer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cyc_req, cyc_write, cyc_drive, cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       busy, addr_valid, rd_strobe, wr_strobe, cyc_done, prefetch_en;
  logic [3:0] drdy_clks;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 0;

  logic [7:0] sh_tmg [4];
  logic [7:0] sh_map, sh_misc;

  pio_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_write(cyc_write),
    .cyc_drive(cyc_drive), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .addr_valid(addr_valid),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .cyc_done(cyc_done),
    .prefetch_en(prefetch_en), .drdy_clks(drdy_clks)
  );

  function automatic int exp_setup();
    return (int'(sh_misc) / 16) % 4 + 1;
  endfunction
  function automatic int exp_bank(bit drv);
    return drv ? int'(sh_map[2]) : int'(sh_map[1]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shadow_apply(logic [2:0] a, logic [7:0] d);
    if (a < 3'd4) sh_tmg[a[1:0]] = d;
    else if (a == 3'd4) sh_map = d;
    else if (a == 3'd5) sh_misc = d;
  endtask

  task automatic cfg_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow_apply(a, d);
  endtask

  // one transfer, checked on every clock; poke adds a request and a
  // register write while the transfer runs (R8, R9)
  task automatic run_cycle(bit drv, bit wr, bit poke, string tag);
    int a, d, r, tot, b;
    logic [2:0] pa;
    logic [7:0] pd;
    logic [4:0] expv;
    string ph;
    b   = int'(sh_tmg[2 * exp_bank(drv) + int'(wr)]);
    a   = exp_setup();
    d   = b / 16 + 1;
    r   = b % 16 + 2;
    tot = a + d + r;
    pa  = 3'($urandom % 8);
    pd  = 8'($urandom);
    @(negedge clk);
    cyc_req = 1'b1; cyc_drive = drv; cyc_write = wr;
    for (int i = 0; i <= tot; i++) begin
      @(negedge clk);
      if (i == 0) cyc_req = 1'b0;
      if (poke && i == 1) begin
        cyc_req = 1'b1; cfg_we = 1'b1; cfg_addr = pa; cfg_wdata = pd;
      end
      if (poke && i == 2) begin
        cyc_req = 1'b0; cfg_we = 1'b0;
        shadow_apply(pa, pd);
      end
      if (i < a) begin expv = 5'b11000; ph = "R3 setup"; end
      else if (i < a + d) begin expv = {2'b11, !wr, wr, 1'b0}; ph = "R2 R5 R6 pulse"; end
      else if (i < tot) begin expv = 5'b10000; ph = "R2 R9 recovery"; end
      else begin expv = 5'b10001; ph = "R7 done"; end
      check({tag, " ", ph}, {27'd0, busy, addr_valid, rd_strobe, wr_strobe, cyc_done},
            {27'd0, expv});
    end
    @(negedge clk);
    check({tag, " R8 idle after"}, {27'd0, busy, addr_valid, rd_strobe, wr_strobe, cyc_done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    rst_n = 1'b0; cyc_req = 1'b0; cyc_write = 1'b0; cyc_drive = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int k = 0; k < 4; k++) sh_tmg[k] = 8'h00;
    sh_map = 8'h00; sh_misc = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {27'd0, busy, addr_valid, rd_strobe, wr_strobe, cyc_done}, 32'd0);
    check("R1 reset prefetch", {31'd0, prefetch_en}, 32'd0);
    check("R1 reset drdy", {28'd0, drdy_clks}, 32'd2);
    rst_n = 1'b1;

    // R1: minimum transfer on every drive and direction
    for (int k = 0; k < 4; k++) run_cycle(k[1], k[0], 1'b0, "R1 min");

    // R2: field extremes
    cfg_write(3'd0, 8'hF0);
    run_cycle(1'b0, 1'b0, 1'b0, "R2 long pulse");
    cfg_write(3'd1, 8'h0F);
    run_cycle(1'b0, 1'b1, 1'b0, "R2 long recovery");

    // R3: shared setup of 4 clocks on both drives
    cfg_write(3'd5, 8'h30);
    run_cycle(1'b1, 1'b0, 1'b0, "R3 drive1");
    run_cycle(1'b0, 1'b1, 1'b0, "R3 drive0");

    // R4, R5: bank mapping and direction bytes
    cfg_write(3'd2, 8'h21);
    cfg_write(3'd3, 8'h43);
    cfg_write(3'd4, 8'h85);
    for (int k = 0; k < 4; k++) run_cycle(k[1], k[0], 1'b0, "R4 map 85");
    cfg_write(3'd4, 8'h02);
    for (int k = 0; k < 4; k++) run_cycle(k[1], k[0], 1'b0, "R4 map 02");

    // R10: prefetch and ready-wait count
    cfg_write(3'd5, 8'h4E);
    check("R10 prefetch", {31'd0, prefetch_en}, 32'd1);
    check("R10 drdy", {28'd0, drdy_clks}, 32'd9);

    // R11: unmapped addresses
    cfg_write(3'd6, 8'hFF);
    cfg_write(3'd7, 8'hA5);
    check("R11 prefetch kept", {31'd0, prefetch_en}, 32'd1);
    check("R11 drdy kept", {28'd0, drdy_clks}, 32'd9);
    for (int k = 0; k < 4; k++) run_cycle(k[1], k[0], 1'b0, "R11 after");

    // R8, R9: request and register write during a transfer
    for (int k = 0; k < 6; k++) run_cycle(k[0], k[1], 1'b1, "R9 poke");

    // random mix
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 3 == 0) cfg_write(3'($urandom % 8), 8'($urandom));
      run_cycle(1'($urandom), 1'($urandom), ($urandom % 4) == 0, "rand R5");
    end
    check("R10 final prefetch", {31'd0, prefetch_en}, {31'd0, sh_misc[6]});
    check("R10 final drdy", {28'd0, drdy_clks}, 32'(int'(sh_misc[3:1]) + 2));

    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule